// File: doc/BRIEF.md
# Serial Word Memory Slave

This block models a small word-organised memory as a slave on a four-wire serial port. It holds 64 words of 16 bits. The serial clock, chip select and data input are sampled by the system clock. Edges of the serial clock are found from those samples, so the whole design runs in one clock domain. The data output is a register.

A master raises chip select and may send any number of zero bits first. It then sends a start bit of 1, a two-bit opcode and a six-bit field, most significant bit first. Opcode 10 reads the word at the address in the field. Opcode 01 writes the 16 bits that follow to that address. Opcode 00 is a control frame: a field whose two top bits are 11 arms a write-enable latch, and a field whose two top bits are 00 disarms it.

The latch is clear after reset, so the memory is protected until the master sends an enable. A write that arrives while the latch is clear is clocked in completely and then discarded. Lowering chip select ends any frame, complete or not.

Top module: `swm_slave`

## Requirements
- R1: While selected and waiting for a frame, rising SCK edges with data in low are ignored. The first rising edge with data in high is the start bit. The next eight rising edges carry the opcode (2 bits) and then the field (6 bits), most significant bit first.
- R2: Opcode 10 returns one dummy bit of 0 on data out, then the 16 bits of the addressed word, most significant bit first. Data out changes only after falling SCK edges, so each bit is valid at the following rising edge.
- R3: Opcode 01, with the write-enable latch set, stores the next 16 bits received (most significant bit first) at the addressed word.
- R4: Opcode 00 with field bits [5:4] equal to 11 sets the write-enable latch, whatever the lower four bits are. Opcode 00 with field bits [5:4] equal to 00 clears it.
- R5: A write frame received while the latch is clear leaves the memory unchanged.
- R6: Synchronous reset clears the write-enable latch and drives data out low. Reset does not change the array contents.
- R7: Lowering chip select at any point abandons the current frame without effect on memory. The next selection starts again by waiting for a start bit.
- R8: Data out is low while chip select is low, including when a read is cut off mid-word.
- R9: Opcode 00 with field bits [5:4] equal to 01 or 10, and opcode 11, change neither the latch nor the memory.
- R10: Once a frame has ended, further SCK edges are ignored until chip select falls. Data out stays low during them, and a second start bit inside the same selection does not begin a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it samples all serial pins |
| rst | input | 1 | Synchronous reset, active high |
| sck | input | 1 | Serial clock from the master |
| cs | input | 1 | Chip select, active high |
| sdi | input | 1 | Serial data from master to slave |
| sdo | output | 1 | Serial data from slave to master, registered |

## Verification
The hardest effect to observe is the latch blocking a write, because a write with no effect and a write that went to the wrong place look the same at the ports. The bench stores a known word while the latch is set and clears the latch (or resets the block, which keeps the array). It then sends a write with a different value to the same address and reads the address back. The first value must return. Aborted frames are handled the same way. Chip select falls partway through a header, a write data phase or a read burst, and later reads confirm that nothing changed. For the cut-off read, data out is also sampled a few cycles after the abort.

// File: rtl/swm_pkg.sv
package swm_pkg;
  localparam int OP_W = 2;

  localparam logic [OP_W-1:0] OP_CTRL  = 2'b00;
  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;
  localparam logic [OP_W-1:0] OP_READ  = 2'b10;

  localparam logic [1:0] CTRL_ARM    = 2'b11;
  localparam logic [1:0] CTRL_DISARM = 2'b00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_RD,
    ST_WR,
    ST_DONE
  } frame_state_t;
endpackage

// File: rtl/swm_edge.sv
module swm_edge #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs,
  input  logic sdi,
  output logic cs_q,
  output logic sdi_q,
  output logic sck_rise,
  output logic sck_fall
);
  localparam int LAST = SYNC_DEPTH - 1;

  logic [SYNC_DEPTH-1:0] sck_p, cs_p, sdi_p;
  logic                  sck_prev;

  generate
    if (SYNC_DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          sck_p <= '0;
          cs_p  <= '0;
          sdi_p <= '0;
        end else begin
          sck_p <= sck;
          cs_p  <= cs;
          sdi_p <= sdi;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          sck_p <= '0;
          cs_p  <= '0;
          sdi_p <= '0;
        end else begin
          sck_p <= {sck_p[SYNC_DEPTH-2:0], sck};
          cs_p  <= {cs_p[SYNC_DEPTH-2:0], cs};
          sdi_p <= {sdi_p[SYNC_DEPTH-2:0], sdi};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= sck_p[LAST];
  end

  assign cs_q     = cs_p[LAST];
  assign sdi_q    = sdi_p[LAST];
  assign sck_rise = cs_p[LAST] & sck_p[LAST] & ~sck_prev;
  assign sck_fall = cs_p[LAST] & ~sck_p[LAST] & sck_prev;
endmodule

// File: rtl/swm_mem.sv
module swm_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    rdata <= store[addr];
  end
endmodule

// File: rtl/swm_frame.sv
module swm_frame
  import swm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_q,
  input  logic              sdi_q,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              wel,
  output logic              sdo
);
  localparam int HDR_W   = OP_W + ADDR_W;
  localparam int CNT_MAX = (HDR_W > DATA_W + 2) ? HDR_W : DATA_W + 2;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  frame_state_t      state;
  logic [HDR_W-2:0]  hdr_sh;
  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;

  logic [HDR_W-1:0]  hdr_full;
  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] field;
  logic [DATA_W-1:0] wr_full;

  assign hdr_full = {hdr_sh, sdi_q};
  assign op       = hdr_full[HDR_W-1 -: OP_W];
  assign field    = hdr_full[ADDR_W-1:0];
  assign wr_full  = {sh[DATA_W-2:0], sdi_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      hdr_sh    <= '0;
      sh        <= '0;
      cnt       <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      wel       <= 1'b0;
      sdo       <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (!cs_q) begin
        state <= ST_IDLE;
        cnt   <= '0;
        sdo   <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (sck_rise && sdi_q) begin
              state <= ST_HDR;
              cnt   <= '0;
            end
          end
          ST_HDR: begin
            if (sck_rise) begin
              hdr_sh <= hdr_full[HDR_W-2:0];
              cnt    <= cnt + 1'b1;
              if (cnt == CNT_W'(HDR_W - 1)) begin
                cnt      <= '0;
                mem_addr <= field;
                case (op)
                  OP_READ:  state <= ST_RD;
                  OP_WRITE: state <= ST_WR;
                  OP_CTRL: begin
                    if (field[ADDR_W-1 -: 2] == CTRL_ARM)         wel <= 1'b1;
                    else if (field[ADDR_W-1 -: 2] == CTRL_DISARM) wel <= 1'b0;
                    state <= ST_DONE;
                  end
                  default: state <= ST_DONE;
                endcase
              end
            end
          end
          ST_RD: begin
            if (sck_fall) begin
              if (cnt == '0) begin
                sdo <= 1'b0;
                sh  <= mem_rdata;
                cnt <= CNT_W'(1);
              end else if (cnt <= CNT_W'(DATA_W)) begin
                sdo <= sh[DATA_W-1];
                sh  <= {sh[DATA_W-2:0], 1'b0};
                cnt <= cnt + 1'b1;
              end else begin
                sdo   <= 1'b0;
                state <= ST_DONE;
              end
            end
          end
          ST_WR: begin
            if (sck_rise) begin
              sh  <= wr_full;
              cnt <= cnt + 1'b1;
              if (cnt == CNT_W'(DATA_W - 1)) begin
                mem_wdata <= wr_full;
                mem_we    <= wel;
                state     <= ST_DONE;
              end
            end
          end
          default: sdo <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/swm_slave.sv
module swm_slave #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs,
  input  logic sdi,
  output logic sdo
);
  logic              cs_q, sdi_q, sck_rise, sck_fall;
  logic              mem_we, wel;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  swm_edge #(.SYNC_DEPTH(SYNC_DEPTH)) u_edge (
    .clk(clk), .rst(rst), .sck(sck), .cs(cs), .sdi(sdi),
    .cs_q(cs_q), .sdi_q(sdi_q), .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  swm_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .cs_q(cs_q), .sdi_q(sdi_q),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wel(wel), .sdo(sdo)
  );

  swm_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );
endmodule

// File: rtl/swm_slave_chk.sv
module swm_slave_chk (
  input logic clk,
  input logic rst,
  input logic cs_q,
  input logic sck_fall,
  input logic sdo,
  input logic wel,
  input logic mem_we
);
  AST_SDO_QUIET_DESELECT: assert property (@(posedge clk) disable iff (rst) !cs_q |=> !sdo); // R8
  AST_WRITE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst) mem_we |-> wel); // R5
  AST_WRITE_WHILE_SELECTED: assert property (@(posedge clk) disable iff (rst) mem_we |-> $past(cs_q)); // R3
  AST_LATCH_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> (!wel && !sdo)); // R6
  AST_SDO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst) !$stable(sdo) |-> ($past(sck_fall) || !$past(cs_q))); // R2
  AST_LATCH_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst) !$stable(wel) |-> $past(cs_q)); // R4
endmodule

bind swm_slave swm_slave_chk u_chk (
  .clk(clk), .rst(rst), .cs_q(cs_q), .sck_fall(sck_fall),
  .sdo(sdo), .wel(wel), .mem_we(mem_we)
);

// File: tb/swm_slave_tb.sv
module swm_slave_tb;
  localparam int HALF = 8;

  typedef struct packed {
    logic [1:0]  kind;   // 0 control, 1 write, 2 read
    logic [5:0]  field;
    logic [15:0] data;
  } vec_t;

  localparam vec_t VEC [16] = '{
    {2'd0, 6'b110101, 16'h0000},
    {2'd1, 6'h05, 16'hA5C3},
    {2'd1, 6'h3F, 16'hFFFF},
    {2'd1, 6'h00, 16'h0001},
    {2'd2, 6'h05, 16'hA5C3},
    {2'd2, 6'h3F, 16'hFFFF},
    {2'd2, 6'h00, 16'h0001},
    {2'd0, 6'b001010, 16'h0000},
    {2'd1, 6'h05, 16'h1234},
    {2'd2, 6'h05, 16'hA5C3},
    {2'd0, 6'b111111, 16'h0000},
    {2'd1, 6'h2A, 16'h8000},
    {2'd2, 6'h2A, 16'h8000},
    {2'd1, 6'h15, 16'h7FFE},
    {2'd2, 6'h15, 16'h7FFE},
    {2'd0, 6'b000000, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic cs  = 1'b0;
  logic sdi = 1'b0;
  logic sdo;
  int   checks = 0;
  int   fails  = 0;
  logic junk;

  always #10 clk = ~clk;

  swm_slave u_dut (.clk(clk), .rst(rst), .sck(sck), .cs(cs), .sdi(sdi), .sdo(sdo));

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick_bit(input logic b, output logic r);
    sdi = b;
    repeat (HALF) @(negedge clk);
    r = sdo;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) tick_bit(v[i], junk);
  endtask

  task automatic sel_on();
    cs = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sel_off();
    sck = 1'b0;
    sdi = 1'b0;
    repeat (2) @(negedge clk);
    cs = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic ctrl(input logic [5:0] f);
    sel_on();
    send_bits({23'd0, 1'b1, 2'b00, f}, 9);
    sel_off();
  endtask

  task automatic write_word(input logic [5:0] f, input logic [15:0] d);
    sel_on();
    send_bits({7'd0, 1'b1, 2'b01, f, d}, 25);
    sel_off();
  endtask

  task automatic read_body(input logic [5:0] f, output logic [15:0] d, output logic dmy);
    logic b;
    send_bits({23'd0, 1'b1, 2'b10, f}, 9);
    tick_bit(1'b0, dmy);
    d = '0;
    for (int i = 0; i < 16; i++) begin
      tick_bit(1'b0, b);
      d = {d[14:0], b};
    end
  endtask

  task automatic read_word(input logic [5:0] f, output logic [15:0] d, output logic dmy);
    sel_on();
    read_body(f, d, dmy);
    sel_off();
  endtask

  task automatic check_read(input string req, input logic [5:0] f, input logic [15:0] exp);
    logic [15:0] d;
    logic        dmy;
    read_word(f, d, dmy);
    chk("R2 dummy", {15'd0, dmy}, 16'h0000);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic        dmy, b;
    repeat (5) @(negedge clk);
    chk("R6 sdo in reset", {15'd0, sdo}, 16'h0000);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 sdo after reset", {15'd0, sdo}, 16'h0000);

    // Table walk: R3 writes, R4 latch control, R5 blocked write, R2 reads
    for (int k = 0; k < 16; k++) begin
      case (VEC[k].kind)
        2'd0: ctrl(VEC[k].field);
        2'd1: write_word(VEC[k].field, VEC[k].data);
        default: check_read("R2 R3 R4 R5 table read", VEC[k].field, VEC[k].data);
      endcase
    end

    // R6: reset clears latch, keeps array
    ctrl(6'b110000);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    write_word(6'h05, 16'h0BAD);
    check_read("R6 latch cleared by reset", 6'h05, 16'hA5C3);

    // R1: leading zeros before start bit
    sel_on();
    send_bits(32'd0, 5);
    read_body(6'h15, d, dmy);
    sel_off();
    chk("R1 leading zeros", d, 16'h7FFE);

    // R9: reserved control fields and opcode 11
    ctrl(6'b110000);
    ctrl(6'b011111);
    write_word(6'h3F, 16'h1111);
    check_read("R9 field 01 keeps latch set", 6'h3F, 16'h1111);
    ctrl(6'b000000);
    ctrl(6'b100000);
    write_word(6'h3F, 16'h2222);
    check_read("R9 field 10 keeps latch clear", 6'h3F, 16'h1111);
    ctrl(6'b110000);
    sel_on();
    send_bits({7'd0, 1'b1, 2'b11, 6'h3F, 16'h3333}, 25);
    sel_off();
    check_read("R9 opcode 11 no write", 6'h3F, 16'h1111);

    // R7: aborts in header and in write data
    sel_on();
    send_bits({29'd0, 3'b101}, 3);
    sel_off();
    check_read("R7 abort in header", 6'h15, 16'h7FFE);
    sel_on();
    send_bits({7'd0, 1'b1, 2'b01, 6'h2A, 16'hFFFF}, 15);
    sel_off();
    check_read("R7 abort in write data", 6'h2A, 16'h8000);

    // R8: cut off a read while data out is high
    sel_on();
    send_bits({23'd0, 1'b1, 2'b10, 6'h3F}, 9);
    for (int i = 0; i < 5; i++) tick_bit(1'b0, b);
    chk("R8 sdo high mid-read", {15'd0, b}, 16'h0001);
    sck = 1'b0;
    cs  = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 sdo low after deselect", {15'd0, sdo}, 16'h0000);
    repeat (4) @(negedge clk);
    check_read("R7 fresh frame after abort", 6'h3F, 16'h1111);

    // R10: edges after end of frame
    sel_on();
    read_body(6'h05, d, dmy);
    for (int i = 0; i < 4; i++) begin
      tick_bit(1'b1, b);
      chk("R10 sdo low after read", {15'd0, b}, 16'h0000);
    end
    sel_off();
    sel_on();
    send_bits({7'd0, 1'b1, 2'b01, 6'h15, 16'h4444}, 25);
    send_bits({7'd0, 1'b1, 2'b01, 6'h2A, 16'h0000}, 25);
    sel_off();
    check_read("R10 second frame ignored", 6'h2A, 16'h8000);
    check_read("R3 first frame stored", 6'h15, 16'h4444);

    report();
    $finish;
  end
endmodule